// File: doc/BRIEF.md
# Peripheral DMA Request Handshake Controller

This block connects a byte-wide instrument-bus peripheral to an external DMA controller. Two flags record that the bus side has a byte waiting to be read (byte-in) and that the outgoing data register is empty and needs a new byte (byte-out). Each flag has its own enable bit. The enabled flags are combined into a single DMA request output.

The DMA controller answers with an active-low acknowledge. While the acknowledge is low, the block ignores chip select and the register-select lines. A host read strobe then always reaches the data-in register, and a host write strobe always reaches the data-out register. The acknowledge also drops the request.

Once a byte has been moved, the block sends a one-cycle pulse to the bus handshake engines. A data-in read produces ready-for-data toward the acceptor. A data-out write produces data-valid toward the source. The host sees separate copies of both flags in a status register. Reading that register clears the host copies only, and leaves the flags that feed the request untouched.

Top module: `dma_hs_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every flag, both enable bits, the status bits, `dreq`, `rfd_pulse` and `dav_pulse`.
- R2: A `bus_byte_vld` pulse latches `bus_byte` into data-in and sets the byte-in flag. If the input enable is set, `dreq` goes high at the following clock edge.
- R3: A `src_empty` pulse sets the byte-out flag. If the output enable is set, `dreq` goes high at the following clock edge.
- R4: `dreq` never rises while the enable bit of every pending flag is clear. `dreq` rises only on a rising edge of the enabled-flag term. Setting an enable while its flag is pending counts as such an edge. An acknowledged request whose flag stays pending does not re-assert.
- R5: When `dack_n` is low at a clock edge, `dreq` is low after that edge.
- R6: While `dack_n` is low, `cs_n` and `reg_sel` are treated as 0. A low `rd_n` reads data-in and a low `wr_n` writes data-out.
- R7: Register select 1 reads status: bit 0 is byte-in and bit 1 is byte-out. A status read clears both status bits at the next edge. It does not clear the DMA flags, so a pending `dreq` stays high.
- R8: A data-in read clears the byte-in DMA flag. A data-out write clears the byte-out DMA flag. The request drops when no enabled flag remains.
- R9: `rfd_pulse` is high for exactly the cycle that follows each data-in read.
- R10: A data-out write loads `bus_dout` and raises `dav_pulse` for the cycle that follows it.
- R11: Register select 2 holds the enables: bit 0 enables input DMA and bit 1 enables output DMA. The register is written and read back through the host port. Select values 3 to 7 read as 0, and `rdata` is 0 when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| reg_sel | input | 3 | Host register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when no read is active |
| dack_n | input | 1 | DMA acknowledge, active low |
| dreq | output | 1 | DMA request |
| bus_byte_vld | input | 1 | Pulse: a byte has been accepted from the bus |
| bus_byte | input | 8 | Byte accepted from the bus |
| src_empty | input | 1 | Pulse: the source handshake has consumed data-out |
| bus_dout | output | 8 | Data-out register toward the bus |
| rfd_pulse | output | 1 | Ready-for-data pulse toward the acceptor handshake |
| dav_pulse | output | 1 | Data-valid pulse toward the source handshake |

## Verification
The bench targets several corner cases:
- A status read while a request is pending. A design that shares one flag between status and request would drop `dreq` there.
- An acknowledge that arrives while the flag is still pending. A level-driven request would re-assert straight away and cause a second DMA cycle for the same byte.
- DMA accesses made with `cs_n` high and a nonzero select. A design without the forced decoding would return status or zero, or miss the data-out load.
- Enabling output DMA after the byte-out flag is already set. A design that misses this case never requests.

The bench also checks that the bus pulses come one cycle after the access and never before it.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  localparam int SEL_W = 3;
  localparam int NCH   = 2;   // channel 0: byte-in, channel 1: byte-out

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 3'd0,
    SEL_STAT = 3'd1,
    SEL_ENA  = 3'd2
  } sel_e;

  // request term: any pending flag whose enable is set
  function automatic logic req_term(input logic [NCH-1:0] flags,
                                    input logic [NCH-1:0] ena);
    return |(flags & ena);
  endfunction

  // next request level from acknowledge, term edge and current level
  function automatic logic req_next(input logic ack, input logic term,
                                    input logic term_q, input logic cur);
    if (ack)                 return 1'b0;
    else if (term && !term_q) return 1'b1;
    else                     return cur && term;
  endfunction
endpackage

// File: rtl/dma_addr_steer.sv
module dma_addr_steer
  import dma_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             dack_n,
  output logic             rd_din,
  output logic             wr_dout,
  output logic             rd_stat,
  output logic             rd_ena,
  output logic             wr_ena,
  output logic             rd_act,
  output logic [SEL_W-1:0] eff_sel
);
  logic sel_on;

  always_comb begin
    sel_on  = !dack_n || !cs_n;
    eff_sel = dack_n ? reg_sel : '0;
    rd_act  = sel_on && !rd_n;
    rd_din  = rd_act && (eff_sel == SEL_DATA);
    rd_stat = rd_act && (eff_sel == SEL_STAT);
    rd_ena  = rd_act && (eff_sel == SEL_ENA);
    wr_dout = sel_on && !wr_n && (eff_sel == SEL_DATA);
    wr_ena  = sel_on && !wr_n && (eff_sel == SEL_ENA);
  end

  // R6: acknowledge overrides chip select and address
  assert_ack_read_R6: assert property (@(posedge clk) disable iff (rst)
    (!dack_n && !rd_n) |-> rd_din);
  assert_ack_write_R6: assert property (@(posedge clk) disable iff (rst)
    (!dack_n && !wr_n) |-> (wr_dout && !wr_ena));
endmodule

// File: rtl/dma_flag_cell.sv
module dma_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_hs_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] ena,
  input  logic           dack_n,
  output logic           dreq,
  output logic           term_o
);
  logic term_q;

  assign term_o = req_term(flags, ena);

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq   <= 1'b0;
      term_q <= 1'b0;
    end else begin
      dreq   <= req_next(!dack_n, term_o, term_q, dreq);
      term_q <= term_o;
    end
  end

  assert_ack_drops_R5: assert property (@(posedge clk) disable iff (rst)
    !dack_n |=> !dreq);
  assert_no_req_unenabled_R4: assert property (@(posedge clk) disable iff (rst)
    !term_o |=> !dreq);
  assert_rise_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dreq) |-> ($past(term_o) && !$past(term_q)));
endmodule

// File: rtl/dma_hs_ctl.sv
module dma_hs_ctl
  import dma_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              dack_n,
  output logic              dreq,
  input  logic              bus_byte_vld,
  input  logic [DATA_W-1:0] bus_byte,
  input  logic              src_empty,
  output logic [DATA_W-1:0] bus_dout,
  output logic              rfd_pulse,
  output logic              dav_pulse
);
  logic             rd_din, wr_dout, rd_stat, rd_ena, wr_ena, rd_act;
  logic [SEL_W-1:0] eff_sel;
  logic [NCH-1:0]   set_v, dma_clr_v, dma_flag, stat_flag, ena;
  logic [DATA_W-1:0] din_q;
  logic             term;

  dma_addr_steer u_steer (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .reg_sel(reg_sel), .dack_n(dack_n), .rd_din(rd_din), .wr_dout(wr_dout),
    .rd_stat(rd_stat), .rd_ena(rd_ena), .wr_ena(wr_ena), .rd_act(rd_act),
    .eff_sel(eff_sel)
  );

  assign set_v     = {src_empty, bus_byte_vld};
  assign dma_clr_v = {wr_dout, rd_din};

  // one request flag and one host status flag per channel
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_flag_cell u_dma (
      .clk(clk), .rst(rst), .set_i(set_v[c]), .clr_i(dma_clr_v[c]),
      .flag_o(dma_flag[c])
    );
    dma_flag_cell u_stat (
      .clk(clk), .rst(rst), .set_i(set_v[c]), .clr_i(rd_stat),
      .flag_o(stat_flag[c])
    );
  end

  dma_req_gen u_req (
    .clk(clk), .rst(rst), .flags(dma_flag), .ena(ena), .dack_n(dack_n),
    .dreq(dreq), .term_o(term)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ena       <= '0;
      din_q     <= '0;
      bus_dout  <= '0;
      rfd_pulse <= 1'b0;
      dav_pulse <= 1'b0;
    end else begin
      if (wr_ena)       ena      <= wdata[NCH-1:0];
      if (bus_byte_vld) din_q    <= bus_byte;
      if (wr_dout)      bus_dout <= wdata;
      rfd_pulse <= rd_din;
      dav_pulse <= wr_dout;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      case (eff_sel)
        SEL_DATA: rdata = din_q;
        SEL_STAT: rdata = {{(DATA_W-NCH){1'b0}}, stat_flag};
        SEL_ENA:  rdata = {{(DATA_W-NCH){1'b0}}, ena};
        default:  rdata = '0;
      endcase
    end
  end

  assert_rfd_follows_read_R9: assert property (@(posedge clk) disable iff (rst)
    rfd_pulse |-> $past(rd_din));
  assert_dav_load_R10: assert property (@(posedge clk) disable iff (rst)
    wr_dout |=> (dav_pulse && bus_dout == $past(wdata)));
  assert_stat_keeps_req_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && dreq && dack_n && term && !rd_din && !wr_dout) |=> dreq);
  assert_stat_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !bus_byte_vld && !src_empty) |=> (stat_flag == '0));
endmodule

// File: tb/sim_dma_hs_ctl.sv
module sim_dma_hs_ctl;
  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1, dack_n = 1;
  logic [2:0] reg_sel = 0;
  logic [7:0] wdata = 0, bus_byte = 0;
  logic bus_byte_vld = 0, src_empty = 0;
  wire  [7:0] rdata, bus_dout;
  wire  dreq, rfd_pulse, dav_pulse;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference state
  bit m_di, m_do, m_sbi, m_sbo, m_tq, m_dreq, m_rfd, m_dav;
  bit [1:0] m_en;
  bit [7:0] m_din, m_dout;

  always #5 clk = ~clk;

  dma_hs_ctl u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .dack_n(dack_n),
    .dreq(dreq), .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte),
    .src_empty(src_empty), .bus_dout(bus_dout), .rfd_pulse(rfd_pulse),
    .dav_pulse(dav_pulse));

  task automatic chk(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    int s;
    bit act;
    s   = dack_n ? int'(reg_sel) : 0;
    act = (!dack_n || !cs_n) && !rd_n;
    if (!act) return 0;
    if (s == 0) return m_din;
    if (s == 1) return {m_sbo, m_sbi};
    if (s == 2) return m_en;
    return 0;
  endfunction

  always @(posedge clk) begin
    int s;
    bit ra, wa, term, nd;
    if (rst) begin
      {m_di, m_do, m_sbi, m_sbo, m_tq, m_dreq, m_rfd, m_dav} = '0;
      m_en = 0; m_din = 0; m_dout = 0;
    end else begin
      s  = dack_n ? int'(reg_sel) : 0;
      ra = (!dack_n || !cs_n) && !rd_n;
      wa = (!dack_n || !cs_n) && !wr_n;
      term = (m_di && m_en[0]) || (m_do && m_en[1]);
      if (!dack_n) nd = 0;
      else if (term && !m_tq) nd = 1;
      else nd = m_dreq && term;
      m_dreq = nd; m_tq = term;
      m_rfd = ra && s == 0;
      m_dav = wa && s == 0;
      if (wa && s == 0) m_dout = wdata;
      if (wa && s == 2) m_en = wdata[1:0];
      if (bus_byte_vld) begin m_din = bus_byte; m_di = 1; m_sbi = 1; end
      else begin
        if (ra && s == 0) m_di = 0;
        if (ra && s == 1) m_sbi = 0;
      end
      if (src_empty) begin m_do = 1; m_sbo = 1; end
      else begin
        if (wa && s == 0) m_do = 0;
        if (ra && s == 1) m_sbo = 0;
      end
    end
    #3;
    chk({tag, " dreq"}, dreq, m_dreq);
    chk({tag, " rfd_pulse R9"}, rfd_pulse, m_rfd);
    chk({tag, " dav_pulse R10"}, dav_pulse, m_dav);
    chk({tag, " bus_dout R10"}, bus_dout, m_dout);
    chk({tag, " rdata"}, rdata, exp_rdata());
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_rd(bit [2:0] s, bit ack, output int v);
    @(negedge clk);
    reg_sel = s; cs_n = ack; dack_n = !ack; rd_n = 0;
    #1 v = rdata;
    @(negedge clk);
    cs_n = 1; dack_n = 1; rd_n = 1; reg_sel = 0;
  endtask

  task automatic host_wr(bit [2:0] s, bit ack, bit [7:0] d);
    @(negedge clk);
    reg_sel = s; cs_n = ack; dack_n = !ack; wr_n = 0; wdata = d;
    @(negedge clk);
    cs_n = 1; dack_n = 1; wr_n = 1; reg_sel = 0;
  endtask

  task automatic pulse_in(bit [7:0] b);
    @(negedge clk);
    bus_byte_vld = 1; bus_byte = b;
    @(negedge clk);
    bus_byte_vld = 0;
  endtask

  task automatic pulse_empty();
    @(negedge clk); src_empty = 1;
    @(negedge clk); src_empty = 0;
  endtask

  initial begin
    int v;
    idle(3);
    rst = 0;
    tag = "R1";
    idle(1);
    chk("R1 dreq after reset", dreq, 0);
    host_rd(2, 0, v); chk("R1 enables after reset", v, 0);
    host_rd(1, 0, v); chk("R1 status after reset", v, 0);

    tag = "R11";
    host_wr(2, 0, 8'h01);
    host_rd(2, 0, v); chk("R11 enable readback", v, 1);
    host_rd(5, 0, v); chk("R11 unused select reads 0", v, 0);

    tag = "R2";
    pulse_in(8'hA5);
    idle(1); chk("R2 dreq after byte-in", dreq, 1);

    tag = "R7";
    host_rd(1, 0, v); chk("R7 status bit0", v, 1);
    idle(1); chk("R7 dreq kept after status read", dreq, 1);
    host_rd(1, 0, v); chk("R7 status cleared", v, 0);

    tag = "R6";
    @(negedge clk);
    reg_sel = 5; cs_n = 1; dack_n = 0; rd_n = 0;
    #1 chk("R6 forced data-in read", rdata, 8'hA5);
    @(negedge clk);
    dack_n = 1; rd_n = 1; reg_sel = 0;
    chk("R5 dreq dropped by ack", dreq, 0);
    chk("R9 rfd after DMA read", rfd_pulse, 1);
    idle(1); chk("R9 rfd one cycle only", rfd_pulse, 0);

    tag = "R4";
    pulse_empty();
    idle(3); chk("R4 no request with output disabled", dreq, 0);
    host_wr(2, 0, 8'h03);
    idle(1); chk("R3 request after enabling output", dreq, 1);

    tag = "R10";
    host_wr(7, 1, 8'h3C);
    chk("R10 bus_dout loaded", bus_dout, 8'h3C);
    chk("R10 dav pulse", dav_pulse, 1);
    idle(1); chk("R8 no request after data-out write", dreq, 0);

    tag = "R3";
    pulse_empty();
    idle(1); chk("R3 dreq after byte-out", dreq, 1);
    host_wr(0, 0, 8'h55);
    idle(1); chk("R8 host write clears out flag", dreq, 0);

    tag = "R8";
    pulse_in(8'h11);
    idle(1); chk("R2 dreq second byte", dreq, 1);
    host_rd(0, 0, v); chk("R8 host data read value", v, 8'h11);
    idle(1); chk("R8 request drops after host read", dreq, 0);

    tag = "R5";
    pulse_in(8'h77);
    idle(1);
    @(negedge clk); dack_n = 0;
    @(negedge clk); dack_n = 1;
    chk("R5 ack drops request", dreq, 0);
    idle(3); chk("R4 no re-request while flag pending", dreq, 0);
    host_rd(0, 0, v);
    pulse_in(8'h78);
    idle(1); chk("R4 re-arm on new byte", dreq, 1);

    tag = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 dreq cleared by reset", dreq, 0);
    host_rd(2, 0, v); chk("R1 enables cleared by reset", v, 0);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule